// File: doc/BRIEF.md
# Hex ASCII UART Debug Transmitter

This block is a transmit-only serial debug port. A parallel value handed to it with a one-cycle write strobe is captured and turned into a fixed-length string of uppercase hexadecimal ASCII characters, most significant nibble first. The string is followed by a carriage return and a line feed, and the characters go out on an asynchronous serial line using 8N1 framing, so that an ordinary terminal shows one value per line.

The clock frequency, the baud rate and the number of hex characters are parameters. The bit period is derived from the first two at elaboration time, so the clock parameter must match the clock actually driving the block. While a value is being sent the block raises `busy`. A strobe given while `busy` is high is dropped without effect, so the user logic decides when a snapshot is worth sending and waits for `busy` to fall before offering the next one.

Top module: `hexdbg_uart_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` is held high (idle) and `busy` is low.
- R2: A strobe (`wr_stb` high for one cycle) while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: A strobe while `busy` is high is ignored: it neither changes the characters sent nor lengthens the busy period, and no extra characters follow.
- R4: The input word is captured when the strobe is accepted. Later changes on `wr_data` do not alter the characters of that value.
- R5: Each value produces exactly NUM_HEX hex characters, the most significant nibble first.
- R6: Nibble values 0 to 9 are sent as bytes 0x30 to 0x39 and values 10 to 15 as bytes 0x41 to 0x46.
- R7: After the digits, byte 0x0D and then byte 0x0A are sent. `busy` stays high until the stop bit of the 0x0A byte has ended and falls within three cycles of that point.
- R8: Each byte is framed as one low start bit, eight data bits sent LSB first, and one high stop bit.
- R9: Every bit lasts exactly DIV clock cycles, where DIV is CLK_HZ divided by BAUD and rounded to the nearest integer. For example, 2 000 000 / 120 000 gives 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle request to send the value on `wr_data` |
| wr_data | input | 4*NUM_HEX | Value to print |
| busy | output | 1 | High while a value and its line terminator are being sent |
| txd | output | 1 | Serial output, idle high |

## Verification
On every cycle the assertions check the idle level of the line outside a transfer, the acceptance of a strobe, that `busy` rises only after a strobe, that each frame opens with a low start bit, and that the line holds steady between bit ticks. The character content, the nibble order, the terminator, the insensitivity to late data changes and to strobes while busy, and the exact bit length after rounding can only be shown by the bench. It decodes the line mid-bit against a queue of expected bytes and measures every low run on the line.

// File: rtl/hexdbg_pkg.sv
package hexdbg_pkg;

   localparam logic [7:0] ASC_CR = 8'h0D;
   localparam logic [7:0] ASC_LF = 8'h0A;

   typedef enum logic [1:0] {
      CH_HEX,
      CH_CR,
      CH_LF,
      CH_DONE
   } char_kind_e;

   function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
      logic [7:0] wide;
      wide = {4'h0, nib};
      if (nib < 4'd10) return 8'h30 + wide;
      else             return 8'h37 + wide;
   endfunction

endpackage

// File: rtl/hexdbg_baud.sv
module hexdbg_baud #(
   parameter int DIV = 434
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("hexdbg_baud: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (!run || cnt == LAST)  cnt <= '0;
      else                           cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/hexdbg_ser.sv
module hexdbg_ser #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] byte_in,
   input  logic                 tick,
   output logic                 active,
   output logic                 txd
);
   localparam int FRAME_W = DATA_BITS + 2;
   localparam int BW      = $clog2(FRAME_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   if (DATA_BITS < 5) begin : g_bad_bits
      $error("hexdbg_ser: DATA_BITS must be at least 5");
   end

   logic [FRAME_W-1:0] sr;
   logic [BW-1:0]      bitno;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         sr     <= '1;
         bitno  <= '0;
      end else if (load && !active) begin
         sr     <= {1'b1, byte_in, 1'b0};
         active <= 1'b1;
         bitno  <= '0;
      end else if (active && tick) begin
         if (bitno == LAST_BIT) active <= 1'b0;
         sr    <= {1'b1, sr[FRAME_W-1:1]};
         bitno <= bitno + 1'b1;
      end
   end

   assign txd = active ? sr[0] : 1'b1;
endmodule

// File: rtl/hexdbg_seq.sv
module hexdbg_seq
   import hexdbg_pkg::*;
#(
   parameter int NUM_HEX = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_stb,
   input  logic [4*NUM_HEX-1:0]   wr_data,
   input  logic                   ser_ready,
   output logic                   load,
   output logic [7:0]             char_out,
   output logic                   busy
);
   localparam int DATA_W = 4 * NUM_HEX;
   localparam int TOTAL  = NUM_HEX + 2;
   localparam int IW     = $clog2(TOTAL + 1);
   localparam logic [IW-1:0] IDX_CR = IW'(NUM_HEX);
   localparam logic [IW-1:0] IDX_LF = IW'(NUM_HEX + 1);

   logic [DATA_W-1:0] hold;
   logic [IW-1:0]     idx;
   char_kind_e        kind;

   always_comb begin
      if (idx < IDX_CR)       kind = CH_HEX;
      else if (idx == IDX_CR) kind = CH_CR;
      else if (idx == IDX_LF) kind = CH_LF;
      else                    kind = CH_DONE;
   end

   always_comb begin
      unique case (kind)
         CH_HEX:  char_out = nib_to_ascii(hold[DATA_W-1 -: 4]);
         CH_CR:   char_out = ASC_CR;
         CH_LF:   char_out = ASC_LF;
         default: char_out = 8'h00;
      endcase
   end

   assign load = busy && ser_ready && (kind != CH_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         hold <= '0;
         idx  <= '0;
      end else if (!busy) begin
         if (wr_stb) begin
            busy <= 1'b1;
            hold <= wr_data;
            idx  <= '0;
         end
      end else if (load) begin
         idx <= idx + 1'b1;
         if (kind == CH_HEX) hold <= hold << 4;
      end else if (kind == CH_DONE && ser_ready) begin
         busy <= 1'b0;
      end
   end
endmodule

// File: rtl/hexdbg_uart_tx.sv
module hexdbg_uart_tx #(
   parameter int CLK_HZ  = 50_000_000,
   parameter int BAUD    = 115_200,
   parameter int NUM_HEX = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [4*NUM_HEX-1:0] wr_data,
   output logic                 busy,
   output logic                 txd
);
   localparam int BAUD_DIV = (CLK_HZ + BAUD / 2) / BAUD;

   if (NUM_HEX < 1) begin : g_bad_hex
      $error("hexdbg_uart_tx: NUM_HEX must be at least 1");
   end
   if (BAUD < 1 || BAUD_DIV < 2) begin : g_bad_rate
      $error("hexdbg_uart_tx: CLK_HZ must be at least twice BAUD");
   end

   logic       ser_active;
   logic       baud_tick;
   logic       ser_load;
   logic [7:0] next_char;

   hexdbg_seq #(.NUM_HEX(NUM_HEX)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .ser_ready (!ser_active),
      .load      (ser_load),
      .char_out  (next_char),
      .busy      (busy)
   );

   hexdbg_baud #(.DIV(BAUD_DIV)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ser_active),
      .tick  (baud_tick)
   );

   hexdbg_ser #(.DATA_BITS(8)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ser_load),
      .byte_in (next_char),
      .tick    (baud_tick),
      .active  (ser_active),
      .txd     (txd)
   );
endmodule

// File: rtl/hexdbg_chk.sv
module hexdbg_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic busy,
   input logic txd,
   input logic ser_active,
   input logic tick
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !busy) |=> busy);

   p_rise_needs_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_stb));

   p_ser_under_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ser_active |-> busy);

   p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_active) |-> !txd);

   p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_active && !tick) |=> $stable(txd));
endmodule

bind hexdbg_uart_tx hexdbg_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .busy       (busy),
   .txd        (txd),
   .ser_active (ser_active),
   .tick       (baud_tick)
);

// File: tb/tb_hexdbg_uart_tx.sv
module tb_hexdbg_uart_tx;
   localparam int CLK_HZ  = 2_000_000;
   localparam int BAUD    = 120_000;
   localparam int NUM_HEX = 4;
   localparam int DW      = 4 * NUM_HEX;
   localparam int DIV     = (CLK_HZ + BAUD / 2) / BAUD;   // 17
   localparam int TOTAL   = NUM_HEX + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          busy;
   logic          txd;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   hexdbg_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .NUM_HEX(NUM_HEX)) dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .busy(busy), .txd(txd)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] hex_char(input logic [3:0] n);
      if (n < 4'd10) return 8'h30 + 8'(n);
      return 8'h41 + 8'(n - 4'd10);
   endfunction

   // send one value; optionally fire a second strobe while busy
   task automatic send_value(input logic [DW-1:0] v, input bit extra_stb);
      int n;
      while (busy) @(negedge clk);
      for (int i = NUM_HEX - 1; i >= 0; i--) exp_q.push_back(hex_char(v[4*i +: 4]));
      exp_q.push_back(8'h0D);
      exp_q.push_back(8'h0A);
      @(negedge clk);
      wr_data = v;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
      wr_data = ~v;   // R4: late change must not matter
      check(busy == 1'b1, "R2", "busy after strobe", int'(busy), 1);
      n = 1;
      while (busy) begin
         @(negedge clk);
         n++;
         if (extra_stb && (n == 300 || n == 700)) begin
            wr_data = 16'hBEEF;
            wr_stb  = 1'b1;
            @(negedge clk);
            n++;
            wr_stb  = 1'b0;
            check(busy == 1'b1, "R3", "busy held through ignored strobe", int'(busy), 1);
         end
      end
      check(n >= TOTAL * 10 * DIV && n <= TOTAL * (10 * DIV + 2) + 3, "R7",
            "busy length", n, TOTAL * 10 * DIV);
      check(txd == 1'b1, "R1", "idle after value", int'(txd), 1);
   endtask

   // monitor: decode frames mid-bit and compare with the scoreboard
   initial begin
      logic [7:0] got;
      logic [7:0] exp;
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            repeat (DIV / 2) @(negedge clk);
            check(txd == 1'b0, "R8", "start bit", int'(txd), 0);
            for (int b = 0; b < 8; b++) begin
               repeat (DIV) @(negedge clk);
               got[b] = txd;
            end
            repeat (DIV) @(negedge clk);
            check(txd == 1'b1, "R8", "stop bit", int'(txd), 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected character", int'(got), 0);
            end else begin
               exp = exp_q.pop_front();
               check(got == exp, "R5 R6 R7", "character", int'(got), int'(exp));
            end
         end
      end
   end

   // R9: every low run on the line is a whole number of bit periods
   initial begin
      int run;
      run = 0;
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) run++;
         else if (run > 0) begin
            check(run % DIV == 0, "R9", "low run length", run, DIV);
            run = 0;
         end
      end
   end

   initial begin
      repeat (150_000) @(posedge clk);
      check(1'b0, "R2", "watchdog expired", 150_000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && txd == 1'b1, "R1", "idle after reset", int'({busy, txd}), 1);

      send_value(16'h0000, 1'b0);
      send_value(16'hFFFF, 1'b0);
      send_value(16'h1234, 1'b0);
      send_value(16'h89AB, 1'b1);   // R3 ignored strobes
      send_value(16'hCDEF, 1'b0);
      send_value(16'h5A7E, 1'b0);   // back to back
      send_value(16'h9A09, 1'b1);

      repeat (10 * DIV) @(negedge clk);
      check(exp_q.size() == 0, "R5", "all characters received", exp_q.size(), 0);
      check(busy == 1'b0 && txd == 1'b1, "R3", "no trailing activity", int'({busy, txd}), 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule